// File: doc/BRIEF.md
# Disk Boot Read Supervisor

This block runs a one-sector boot read against a disk controller that shares a word-wide memory with it. When started, it builds a command block in memory and hands the block's address to the controller through a four-word mailbox. It then polls the status word that the controller fills in. The polling has two limits. A fixed number of reads makes up one wait. A fixed number of extra waits is allowed before the controller counts as silent. Completion is recognised by a marker field in the status word, not by a done line.

Stored status with an error field of zero ends the boot with success and a start address of 1. Stored status with a non-zero error field runs the whole sequence again, with a fresh timeout budget, up to a total number of attempts. If the controller never stores status, or every attempt comes back bad, the block raises a sticky failure flag and drives an error code that tells the two causes apart.

Top module: `boot_read_sup`

## Requirements
- R1: After a reset cycle, `done`, `failed`, `err_code`, `start_addr` and `mem_req` are all zero.
- R2: A memory access is held with unchanged address, direction and write data from the cycle `mem_req` rises until a cycle in which `mem_ready` is high. The access completes in that cycle, and read data is taken from `mem_rdata` then.
- R3: Each attempt first writes zero to mailbox words MBOX_BASE+0..3 (default 520 octal). It then writes the command block at CB_BASE (default 1000 octal): +0 = 0, +1 = 0 (status), +2 = 44000 octal (read header, label and data), +3 = 2000 octal (header buffer), +4 = 402 octal (label buffer), +5 = 1 (data buffer), +9 = 1 (disk address 0 with the restore bit). Last, it writes the mailbox words +0..+3 in that order as 0, CB_BASE, 0, 1. The final word forces a seek. No status read happens before the mailbox is posted.
- R4: Status polls read only address CB_BASE+1. A status word is stored when bits [11:8] equal 4'hF. Stored status is good when bits [7:0] are all zero.
- R5: One wait is up to POLL_LIMIT reads that do not see stored status. When a wait runs out, a new wait starts, up to TO_RETRIES extra waits per attempt.
- R6: When every wait of an attempt runs out, `failed` rises and `err_code` becomes ERR_NO_STATUS (default 16'h00D1).
- R7: Stored status that is not good restarts the full sequence of R3, with the wait budget of R5 reloaded, up to BOOT_TRIES attempts in total.
- R8: Stored bad status on the last allowed attempt raises `failed` with `err_code` = ERR_BAD_BOOT (default 16'h00B2).
- R9: Stored good status raises `done`, with `start_addr` = 1 and `err_code` = 0.
- R10: `done` and `failed` are exclusive and stay set until reset. After either one is set, no memory access is issued and `start` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the boot sequence (acted on when idle) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| done | output | 1 | Boot read succeeded |
| failed | output | 1 | Boot read gave up |
| err_code | output | 16 | Failure cause |
| start_addr | output | 16 | Start address after success |

## Verification
The patterns vary how many non-stored reads the controller returns per attempt and how many attempts end with bad status. The stall lengths sit just under, at and past each wait boundary and the whole wait budget, so an off-by-one in the read or wait limit changes the read count or the outcome. The bad-status counts sit below, at and beyond the attempt limit. Combining long stalls with bad status shows whether the wait budget is reloaded per attempt. Near-miss status markers check the exact marker test. The final memory image and the order of mailbox writes against status reads check the command block and the posting sequence.

// File: rtl/boot_sup_pkg.sv
package boot_sup_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WRITE,
    S_POLL,
    S_DONE,
    S_FAIL
  } sup_state_t;

  localparam logic [15:0] DISK_CMD_READ3 = 16'o44000;
  localparam logic [15:0] HDR_BUF        = 16'o2000;
  localparam logic [15:0] LBL_BUF        = 16'o402;
  localparam logic [15:0] DATA_BUF       = 16'o1;
  localparam logic [15:0] DADDR_RESTORE  = 16'o1;
  localparam logic [15:0] BOOT_START     = 16'd1;
  localparam int          N_STEPS        = 15;
  localparam int          STEP_W         = 4;
endpackage

// File: rtl/boot_step_rom.sv
module boot_step_rom
  import boot_sup_pkg::*;
#(
  parameter logic [15:0] MBOX_BASE = 16'o520,
  parameter logic [15:0] CB_BASE   = 16'o1000
) (
  input  logic [STEP_W-1:0] step,
  output logic [15:0]       addr,
  output logic [15:0]       data
);
  always_comb begin
    addr = MBOX_BASE;
    data = 16'd0;
    case (step)
      4'd0, 4'd1, 4'd2, 4'd3: begin
        addr = MBOX_BASE + {12'd0, step};
        data = 16'd0;
      end
      4'd4:  begin addr = CB_BASE;         data = 16'd0;          end
      4'd5:  begin addr = CB_BASE + 16'd1; data = 16'd0;          end
      4'd6:  begin addr = CB_BASE + 16'd2; data = DISK_CMD_READ3; end
      4'd7:  begin addr = CB_BASE + 16'd3; data = HDR_BUF;        end
      4'd8:  begin addr = CB_BASE + 16'd4; data = LBL_BUF;        end
      4'd9:  begin addr = CB_BASE + 16'd5; data = DATA_BUF;       end
      4'd10: begin addr = CB_BASE + 16'd9; data = DADDR_RESTORE;  end
      4'd11: begin addr = MBOX_BASE;         data = 16'd0;   end
      4'd12: begin addr = MBOX_BASE + 16'd1; data = CB_BASE; end
      4'd13: begin addr = MBOX_BASE + 16'd2; data = 16'd0;   end
      4'd14: begin addr = MBOX_BASE + 16'd3; data = 16'd1;   end
      default: begin addr = MBOX_BASE; data = 16'd0; end
    endcase
  end
endmodule

// File: rtl/boot_tally.sv
module boot_tally #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/disk_stat_decode.sv
module disk_stat_decode (
  input  logic [15:0] word,
  output logic        stored,
  output logic        good
);
  assign stored = (word[11:8] == 4'hF);
  assign good   = (word[7:0] == 8'h00);
endmodule

// File: rtl/boot_read_sup.sv
module boot_read_sup
  import boot_sup_pkg::*;
#(
  parameter logic [15:0] MBOX_BASE     = 16'o520,
  parameter logic [15:0] CB_BASE       = 16'o1000,
  parameter int          POLL_LIMIT    = 16384,
  parameter int          TO_RETRIES    = 16,
  parameter int          BOOT_TRIES    = 8,
  parameter logic [15:0] ERR_NO_STATUS = 16'h00D1,
  parameter logic [15:0] ERR_BAD_BOOT  = 16'h00B2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_ready,
  output logic        done,
  output logic        failed,
  output logic [15:0] err_code,
  output logic [15:0] start_addr
);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int WAIT_W = $clog2(TO_RETRIES + 2);
  localparam int TRY_W  = $clog2(BOOT_TRIES + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

  sup_state_t        state;
  logic [STEP_W-1:0] step;
  logic [15:0]       rom_addr, rom_data;
  logic              st_stored, st_good;
  logic [POLL_W-1:0] poll_cnt;
  logic [WAIT_W-1:0] wait_cnt;
  logic [TRY_W-1:0]  try_cnt;
  logic poll_clr, poll_inc, wait_clr, wait_inc, try_clr, try_inc;
  logic xfer, poll_last, wait_last, try_last;

  boot_step_rom #(.MBOX_BASE(MBOX_BASE), .CB_BASE(CB_BASE)) u_rom (
    .step(step), .addr(rom_addr), .data(rom_data)
  );

  disk_stat_decode u_dec (
    .word(mem_rdata), .stored(st_stored), .good(st_good)
  );

  boot_tally #(.W(POLL_W)) u_poll (
    .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .cnt(poll_cnt)
  );
  boot_tally #(.W(WAIT_W)) u_wait (
    .clk(clk), .rst(rst), .clr(wait_clr), .inc(wait_inc), .cnt(wait_cnt)
  );
  boot_tally #(.W(TRY_W)) u_try (
    .clk(clk), .rst(rst), .clr(try_clr), .inc(try_inc), .cnt(try_cnt)
  );

  assign xfer      = mem_req && mem_ready;
  assign poll_last = (poll_cnt == POLL_W'(POLL_LIMIT - 1));
  assign wait_last = (wait_cnt == WAIT_W'(TO_RETRIES));
  assign try_last  = (try_cnt  == TRY_W'(BOOT_TRIES - 1));

  assign mem_req   = (state == S_WRITE) || (state == S_POLL);
  assign mem_we    = (state == S_WRITE);
  assign mem_addr  = (state == S_WRITE) ? rom_addr : (CB_BASE + 16'd1);
  assign mem_wdata = (state == S_WRITE) ? rom_data : 16'd0;

  always_comb begin
    poll_clr = 1'b0; poll_inc = 1'b0;
    wait_clr = 1'b0; wait_inc = 1'b0;
    try_clr  = 1'b0; try_inc  = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        poll_clr = 1'b1; wait_clr = 1'b1; try_clr = 1'b1;
      end
      S_POLL: if (xfer) begin
        if (st_stored) begin
          if (!st_good && !try_last) begin
            try_inc = 1'b1; poll_clr = 1'b1; wait_clr = 1'b1;
          end
        end else if (poll_last) begin
          if (!wait_last) begin
            wait_inc = 1'b1; poll_clr = 1'b1;
          end
        end else begin
          poll_inc = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      step       <= '0;
      done       <= 1'b0;
      failed     <= 1'b0;
      err_code   <= 16'd0;
      start_addr <= 16'd0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_WRITE;
          step  <= '0;
        end
        S_WRITE: if (xfer) begin
          if (step == LAST_STEP) state <= S_POLL;
          else                   step  <= step + 1'b1;
        end
        S_POLL: if (xfer) begin
          if (st_stored) begin
            if (st_good) begin
              state      <= S_DONE;
              done       <= 1'b1;
              start_addr <= BOOT_START;
            end else if (try_last) begin
              state    <= S_FAIL;
              failed   <= 1'b1;
              err_code <= ERR_BAD_BOOT;
            end else begin
              state <= S_WRITE;
              step  <= '0;
            end
          end else if (poll_last && wait_last) begin
            state    <= S_FAIL;
            failed   <= 1'b1;
            err_code <= ERR_NO_STATUS;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/boot_read_sup_chk.sv
module boot_read_sup_chk #(
  parameter logic [15:0] CB_BASE       = 16'o1000,
  parameter logic [15:0] ERR_NO_STATUS = 16'h00D1,
  parameter logic [15:0] ERR_BAD_BOOT  = 16'h00B2
) (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_ready,
  input logic        done,
  input logic        failed,
  input logic [15:0] err_code,
  input logic [15:0] start_addr
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!mem_req && !done && !failed && err_code == 16'd0 && start_addr == 16'd0)); // R1
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R2
  AST_POLL_ADDR: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_addr == CB_BASE + 16'd1)); // R4
  AST_NO_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
    failed |-> (err_code == ERR_NO_STATUS || err_code == ERR_BAD_BOOT)); // R6
  AST_GOOD_START: assert property (@(posedge clk) disable iff (rst)
    done |-> (start_addr == 16'd1 && err_code == 16'd0)); // R9
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    failed |=> (failed && !done)); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !failed)); // R10
  AST_END_QUIET: assert property (@(posedge clk) disable iff (rst)
    (done || failed) |-> !mem_req); // R10
endmodule

bind boot_read_sup boot_read_sup_chk #(
  .CB_BASE(CB_BASE), .ERR_NO_STATUS(ERR_NO_STATUS), .ERR_BAD_BOOT(ERR_BAD_BOOT)
) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .done(done), .failed(failed),
  .err_code(err_code), .start_addr(start_addr)
);

// File: tb/sim_boot_read_sup.sv
`timescale 1ns/100ps
module sim_boot_read_sup;
  localparam logic [15:0] MBOX = 16'o520;
  localparam logic [15:0] CB   = 16'o1000;
  localparam logic [15:0] NS   = 16'h00D1;
  localparam logic [15:0] BB   = 16'h00B2;
  // row: stall(16) bad(8) exp_fail(8) code(16) attempts(8) reads(16)
  localparam int NV = 13;
  localparam logic [71:0] VECS [NV] = '{
    {16'd0,  8'd0, 8'd0, 16'h0000, 8'd1, 16'd1},   // R9 immediate good
    {16'd3,  8'd0, 8'd0, 16'h0000, 8'd1, 16'd4},   // R5 short stall
    {16'd4,  8'd0, 8'd0, 16'h0000, 8'd1, 16'd5},   // R5 last read of first wait
    {16'd5,  8'd0, 8'd0, 16'h0000, 8'd1, 16'd6},   // R5 one timeout
    {16'd14, 8'd0, 8'd0, 16'h0000, 8'd1, 16'd15},  // R5 final read of budget
    {16'd15, 8'd0, 8'd1, 16'h00D1, 8'd1, 16'd15},  // R6 no status
    {16'd0,  8'd1, 8'd0, 16'h0000, 8'd2, 16'd2},   // R7 one bad
    {16'd0,  8'd2, 8'd0, 16'h0000, 8'd3, 16'd3},   // R7 good on last try
    {16'd0,  8'd3, 8'd1, 16'h00B2, 8'd3, 16'd3},   // R8 all bad
    {16'd2,  8'd1, 8'd0, 16'h0000, 8'd2, 16'd6},   // R7 stall per attempt
    {16'd14, 8'd1, 8'd0, 16'h0000, 8'd2, 16'd30},  // R7 wait budget reloaded
    {16'd14, 8'd3, 8'd1, 16'h00B2, 8'd3, 16'd45},  // R8 after long waits
    {16'd15, 8'd1, 8'd1, 16'h00D1, 8'd1, 16'd15}   // R6 before any bad
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mem_req, mem_we, mem_ready, done, failed;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, err_code, start_addr;

  always #2.5 clk = ~clk;

  boot_read_sup #(
    .MBOX_BASE(MBOX), .CB_BASE(CB), .POLL_LIMIT(5), .TO_RETRIES(2), .BOOT_TRIES(3),
    .ERR_NO_STATUS(NS), .ERR_BAD_BOOT(BB)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .done(done), .failed(failed), .err_code(err_code),
    .start_addr(start_addr)
  );

  // memory and controller model
  logic [15:0] mem [0:1023];
  int stall_n = 0;
  int bad_n = 0;
  int attempts, reads, rd_att, early_reads, writes, lat_cnt, txn;
  int cmp = 0;
  int mis = 0;
  int cyc = 0;
  logic ready_q;
  logic [15:0] rdata_q;
  assign mem_ready = ready_q;
  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0; rdata_q <= 16'd0;
      attempts <= 0; reads <= 0; rd_att <= 0; early_reads <= 0;
      writes <= 0; lat_cnt <= 0; txn <= 0;
      for (int i = 0; i < 1024; i++) mem[i] <= 16'hDEAD;
    end else if (ready_q) begin
      ready_q <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt >= (txn % 3)) begin
        lat_cnt <= 0;
        txn <= txn + 1;
        ready_q <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[9:0]] <= mem_wdata;
          writes <= writes + 1;
          if (mem_addr == CB + 16'd1) begin
            attempts <= attempts + 1;
            rd_att <= 0;
          end
        end else begin
          reads <= reads + 1;
          rd_att <= rd_att + 1;
          if (mem[MBOX[9:0] + 10'd1] != CB) early_reads <= early_reads + 1;
          if (rd_att < stall_n)        rdata_q <= (rd_att % 2 == 0) ? 16'h0E00 : 16'h0700;
          else if (attempts <= bad_n)  rdata_q <= 16'h0F80;
          else                         rdata_q <= 16'h0F00;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      mis = mis + 1;
      cmp = cmp + 1;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    cmp = cmp + 1;
    if (act !== exp) begin
      mis = mis + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int stall, input int bad);
    stall_n = stall;
    bad_n = bad;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (done || failed) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 failed", {31'd0, failed}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 err_code", {16'd0, err_code}, 32'd0);
    chk("R1 start_addr", {16'd0, start_addr}, 32'd0);

    // table walk: R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [71:0] r;
      r = VECS[v];
      run(int'(r[71:56]), int'(r[55:48]));
      chk($sformatf("R9/R6/R8 row%0d done", v), {31'd0, done}, {31'd0, ~r[40]});
      chk($sformatf("R6/R8 row%0d failed", v), {31'd0, failed}, {31'd0, r[40]});
      chk($sformatf("R6/R8 row%0d err_code", v), {16'd0, err_code}, {16'd0, r[39:24]});
      chk($sformatf("R7 row%0d attempts", v), attempts, {24'd0, r[23:16]});
      chk($sformatf("R5 row%0d reads", v), reads, {16'd0, r[15:0]});
      chk($sformatf("R3 row%0d writes", v), writes, 32'(15 * int'(r[23:16])));
      if (!r[40]) chk($sformatf("R9 row%0d start_addr", v), {16'd0, start_addr}, 32'd1);
    end

    // R3 memory image and ordering
    run(2, 1);
    chk("R3 mbox0", {16'd0, mem[MBOX[9:0]]}, 32'd0);
    chk("R3 mbox1", {16'd0, mem[MBOX[9:0] + 10'd1]}, {16'd0, CB});
    chk("R3 mbox2", {16'd0, mem[MBOX[9:0] + 10'd2]}, 32'd0);
    chk("R3 mbox3", {16'd0, mem[MBOX[9:0] + 10'd3]}, 32'd1);
    chk("R3 cb0", {16'd0, mem[CB[9:0]]}, 32'd0);
    chk("R3 cmd", {16'd0, mem[CB[9:0] + 10'd2]}, 32'o44000);
    chk("R3 hdr", {16'd0, mem[CB[9:0] + 10'd3]}, 32'o2000);
    chk("R3 lbl", {16'd0, mem[CB[9:0] + 10'd4]}, 32'o402);
    chk("R3 data", {16'd0, mem[CB[9:0] + 10'd5]}, 32'd1);
    chk("R3 daddr", {16'd0, mem[CB[9:0] + 10'd9]}, 32'd1);
    chk("R3 unused cb6", {16'd0, mem[CB[9:0] + 10'd6]}, 32'hDEAD);
    chk("R3 read before post", early_reads, 0);

    // R10 start ignored once finished
    begin
      int w0;
      int r0;
      w0 = writes;
      r0 = reads;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      chk("R10 no writes after done", writes, w0);
      chk("R10 no reads after done", reads, r0);
      chk("R10 done held", {31'd0, done}, 32'd1);
      chk("R10 failed low", {31'd0, failed}, 32'd0);
    end
    run(15, 0);
    repeat (20) @(negedge clk);
    chk("R10 failed held", {31'd0, failed}, 32'd1);
    chk("R10 quiet after fail", {31'd0, mem_req}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
    $finish;
  end
endmodule